// File: doc/BRIEF.md
# Bus-Master Access Firewall

This block sits between the masters of an on-chip bus and one memory-mapped target. It screens every read or write request against a single protected address window. A request whose address falls outside the window goes through unchanged. A request inside the window goes through only if its master identifier is enabled in an allow mask and, when the privileged-only switch is on, only if it also carries the privileged attribute. A rejected request never reaches the target. The firewall answers it with an error response, and a rejected read returns all-zero data.

The window bounds, the allow mask and the control bits are held in a small register file. That register file is reached only through a separate configuration port, never through the screened request path. Writing the lock bit freezes the configuration until the next reset. A sticky record keeps the master identifier and the address of the first rejected request.

Both request channels and both response channels use valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. A sender keeps valid and its payload steady until that edge, and a receiver may hold ready low for as long as it needs. The block handles one transaction at a time. It accepts a new request only after the response to the previous one has been taken.

Top module: `acc_firewall`

## Requirements
- R1: A request whose address is below the window base or above the window limit (both bounds inclusive) is forwarded to the target with the same write flag, identifier, address and write data, whatever its identifier and privilege.
- R2: With the privileged-only bit clear, a request inside the window whose identifier has its bit set in the allow mask (bit n of the mask enables identifier n) is forwarded.
- R3: A request inside the window whose identifier bit is clear in the allow mask is not forwarded. It is answered with the error flag set and zero read data, for reads and for writes alike.
- R4: With the privileged-only bit set, a request inside the window without the privileged attribute is rejected as in R3 even if its identifier is allowed. Privileged requests from allowed identifiers, and any request outside the window, still pass.
- R5: A request is accepted only while the block is idle (the request ready output is high only then). The forwarded request holds valid and payload steady until the target takes it.
- R6: The target's response (error flag and read data) is returned to the master unchanged, and the master response stays valid and steady until the master takes it.
- R7: The error response to a rejected request becomes valid in the cycle right after the request was accepted.
- R8: Configuration offsets: 0 window base, 1 window limit, 2 allow mask, 3 control (bit 0 privileged-only, bit 1 lock). The read data shows the register at the current offset in the same cycle. Unused offsets read zero, and a write takes effect at the clock edge. The screening of a request uses the register values from before that edge.
- R9: After a write sets the lock bit, writes to offsets 0 to 3 have no effect until reset.
- R10: Offset 4 shows the violation record: bit 31 is the valid flag and the low bits hold the identifier. Offset 5 holds the address. Only the first rejected request after reset is recorded, and both offsets ignore writes.
- R11: Out of reset every configuration register and the violation record read zero, the request ready output is high and no valid output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Firewall can accept a request |
| m_req_write | input | 1 | 1 = write, 0 = read |
| m_req_id | input | ID_W | Master identifier |
| m_req_priv | input | 1 | Privileged attribute |
| m_req_addr | input | ADDR_W | Request address |
| m_req_wdata | input | DATA_W | Write data |
| m_rsp_valid | output | 1 | Response to master valid |
| m_rsp_ready | input | 1 | Master takes the response |
| m_rsp_err | output | 1 | Error response |
| m_rsp_rdata | output | DATA_W | Read data to master |
| s_req_valid | output | 1 | Forwarded request valid |
| s_req_ready | input | 1 | Target accepts the request |
| s_req_write | output | 1 | Forwarded write flag |
| s_req_id | output | ID_W | Forwarded identifier |
| s_req_addr | output | ADDR_W | Forwarded address |
| s_req_wdata | output | DATA_W | Forwarded write data |
| s_rsp_valid | input | 1 | Target response valid |
| s_rsp_ready | output | 1 | Firewall takes the target response |
| s_rsp_err | input | 1 | Target error flag |
| s_rsp_rdata | input | DATA_W | Target read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |

## Verification
The hold checks on the outbound request and the master response assume the neighbours keep to the handshake rules. The master keeps its request fields steady while valid is high and ready is low. The target raises its response valid only while a forwarded request is outstanding and keeps it high until it is taken. The stimulus follows both rules. The master task holds valid until it sees ready, then drops it. The emulated target raises its response only after it has taken a request, after a short latency, and lowers it once the response is consumed. The ready inputs toggle freely, since the handshake rules permit that.

// File: rtl/fw_pkg.sv
package fw_pkg;

  localparam int CFG_W = 32;
  localparam int CFG_AW = 3;

  localparam logic [CFG_AW-1:0] CFG_BASE  = 3'd0;
  localparam logic [CFG_AW-1:0] CFG_LIMIT = 3'd1;
  localparam logic [CFG_AW-1:0] CFG_ALLOW = 3'd2;
  localparam logic [CFG_AW-1:0] CFG_CTRL  = 3'd3;
  localparam logic [CFG_AW-1:0] CFG_VSTAT = 3'd4;
  localparam logic [CFG_AW-1:0] CFG_VADDR = 3'd5;

  localparam int CTRL_PRIV_BIT   = 0;
  localparam int CTRL_LOCK_BIT   = 1;
  localparam int VSTAT_VALID_BIT = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } fw_state_e;

endpackage

// File: rtl/fw_cfg_regs.sv
module fw_cfg_regs
  import fw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we_i,
  input  logic [CFG_AW-1:0]       cfg_addr_i,
  input  logic [CFG_W-1:0]        cfg_wdata_i,
  output logic [CFG_W-1:0]        cfg_rdata_o,
  output logic [ADDR_W-1:0]       base_o,
  output logic [ADDR_W-1:0]       limit_o,
  output logic [(1<<ID_W)-1:0]    allow_o,
  output logic                    priv_only_o,
  input  logic                    viol_set_i,
  input  logic [ID_W-1:0]         viol_id_i,
  input  logic [ADDR_W-1:0]       viol_addr_i
);
  localparam int NUM_IDS = 1 << ID_W;

  logic [ADDR_W-1:0]  base_q, limit_q, vaddr_q;
  logic [NUM_IDS-1:0] allow_q;
  logic               priv_q, lock_q, vvalid_q;
  logic [ID_W-1:0]    vid_q;
  logic               wr_en;

  assign wr_en = cfg_we_i && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      allow_q <= '0;
      priv_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else if (wr_en) begin
      case (cfg_addr_i)
        CFG_BASE:  base_q  <= cfg_wdata_i[ADDR_W-1:0];
        CFG_LIMIT: limit_q <= cfg_wdata_i[ADDR_W-1:0];
        CFG_ALLOW: allow_q <= cfg_wdata_i[NUM_IDS-1:0];
        CFG_CTRL: begin
          priv_q <= cfg_wdata_i[CTRL_PRIV_BIT];
          lock_q <= cfg_wdata_i[CTRL_LOCK_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vvalid_q <= 1'b0;
      vid_q    <= '0;
      vaddr_q  <= '0;
    end else if (viol_set_i && !vvalid_q) begin
      vvalid_q <= 1'b1;
      vid_q    <= viol_id_i;
      vaddr_q  <= viol_addr_i;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      CFG_BASE:  cfg_rdata_o = CFG_W'(base_q);
      CFG_LIMIT: cfg_rdata_o = CFG_W'(limit_q);
      CFG_ALLOW: cfg_rdata_o = CFG_W'(allow_q);
      CFG_CTRL: begin
        cfg_rdata_o[CTRL_PRIV_BIT] = priv_q;
        cfg_rdata_o[CTRL_LOCK_BIT] = lock_q;
      end
      CFG_VSTAT: begin
        cfg_rdata_o[VSTAT_VALID_BIT] = vvalid_q;
        cfg_rdata_o[ID_W-1:0]        = vid_q;
      end
      CFG_VADDR: cfg_rdata_o = CFG_W'(vaddr_q);
      default: ;
    endcase
  end

  assign base_o      = base_q;
  assign limit_o     = limit_q;
  assign allow_o     = allow_q;
  assign priv_only_o = priv_q;

  // R9
  cfg_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q && $stable(base_q) && $stable(limit_q) && $stable(allow_q) && $stable(priv_q));

  // R10
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vvalid_q |=> vvalid_q && $stable(vid_q) && $stable(vaddr_q));

endmodule

// File: rtl/fw_rule_check.sv
module fw_rule_check #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [ID_W-1:0]      id_i,
  input  logic                 priv_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [ADDR_W-1:0]    limit_i,
  input  logic [(1<<ID_W)-1:0] allow_i,
  input  logic                 priv_only_i,
  output logic                 in_window_o,
  output logic                 pass_o
);
  logic id_ok, ctx_ok;

  assign in_window_o = (addr_i >= base_i) && (addr_i <= limit_i);
  assign id_ok       = allow_i[id_i];
  assign ctx_ok      = !priv_only_i || priv_i;
  assign pass_o      = !in_window_o || (id_ok && ctx_ok);

endmodule

// File: rtl/fw_txn_ctrl.sv
module fw_txn_ctrl
  import fw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              pass_i,
  output logic              fwd_valid_o,
  input  logic              fwd_ready_i,
  output logic              fwd_write_o,
  output logic [ID_W-1:0]   fwd_id_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic [DATA_W-1:0] fwd_wdata_o,
  input  logic              dn_rsp_valid_i,
  output logic              dn_rsp_ready_o,
  input  logic              dn_rsp_err_i,
  input  logic [DATA_W-1:0] dn_rsp_rdata_i,
  output logic              up_rsp_valid_o,
  input  logic              up_rsp_ready_i,
  output logic              up_rsp_err_o,
  output logic [DATA_W-1:0] up_rsp_rdata_o,
  output logic              reject_o
);
  fw_state_e         st_q, st_d;
  logic              accept;
  logic              h_write;
  logic [ID_W-1:0]   h_id;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic              r_err;
  logic [DATA_W-1:0] r_rdata;

  assign accept   = req_valid_i && (st_q == ST_IDLE);
  assign reject_o = accept && !pass_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req_valid_i) st_d = pass_i ? ST_FWD : ST_RSP;
      ST_FWD:  if (fwd_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (dn_rsp_valid_i) st_d = ST_RSP;
      ST_RSP:  if (up_rsp_ready_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_write <= 1'b0;
      h_id    <= '0;
      h_addr  <= '0;
      h_wdata <= '0;
    end else if (accept) begin
      h_write <= req_write_i;
      h_id    <= req_id_i;
      h_addr  <= req_addr_i;
      h_wdata <= req_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_err   <= 1'b0;
      r_rdata <= '0;
    end else if (reject_o) begin
      r_err   <= 1'b1;
      r_rdata <= '0;
    end else if (st_q == ST_WAIT && dn_rsp_valid_i) begin
      r_err   <= dn_rsp_err_i;
      r_rdata <= dn_rsp_rdata_i;
    end
  end

  assign req_ready_o    = (st_q == ST_IDLE);
  assign fwd_valid_o    = (st_q == ST_FWD);
  assign dn_rsp_ready_o = (st_q == ST_WAIT);
  assign up_rsp_valid_o = (st_q == ST_RSP);
  assign fwd_write_o    = h_write;
  assign fwd_id_o       = h_id;
  assign fwd_addr_o     = h_addr;
  assign fwd_wdata_o    = h_wdata;
  assign up_rsp_err_o   = r_err;
  assign up_rsp_rdata_o = r_rdata;

  // R5
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid_o && !fwd_ready_i |=> fwd_valid_o && $stable(fwd_addr_o) && $stable(fwd_wdata_o)
      && $stable(fwd_id_o) && $stable(fwd_write_o));

  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid_o && !up_rsp_ready_i |=> up_rsp_valid_o && $stable(up_rsp_err_o) && $stable(up_rsp_rdata_o));

endmodule

// File: rtl/acc_firewall.sv
module acc_firewall
  import fw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req_valid,
  output logic              m_req_ready,
  input  logic              m_req_write,
  input  logic [ID_W-1:0]   m_req_id,
  input  logic              m_req_priv,
  input  logic [ADDR_W-1:0] m_req_addr,
  input  logic [DATA_W-1:0] m_req_wdata,
  output logic              m_rsp_valid,
  input  logic              m_rsp_ready,
  output logic              m_rsp_err,
  output logic [DATA_W-1:0] m_rsp_rdata,
  output logic              s_req_valid,
  input  logic              s_req_ready,
  output logic              s_req_write,
  output logic [ID_W-1:0]   s_req_id,
  output logic [ADDR_W-1:0] s_req_addr,
  output logic [DATA_W-1:0] s_req_wdata,
  input  logic              s_rsp_valid,
  output logic              s_rsp_ready,
  input  logic              s_rsp_err,
  input  logic [DATA_W-1:0] s_rsp_rdata,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  localparam int NUM_IDS = 1 << ID_W;

  logic [ADDR_W-1:0]  base, limit;
  logic [NUM_IDS-1:0] allow;
  logic               priv_only, in_window, pass, reject;

  fw_cfg_regs #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .base_o(base), .limit_o(limit), .allow_o(allow), .priv_only_o(priv_only),
    .viol_set_i(reject), .viol_id_i(m_req_id), .viol_addr_i(m_req_addr)
  );

  fw_rule_check #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_rule (
    .addr_i(m_req_addr), .id_i(m_req_id), .priv_i(m_req_priv),
    .base_i(base), .limit_i(limit), .allow_i(allow), .priv_only_i(priv_only),
    .in_window_o(in_window), .pass_o(pass)
  );

  fw_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(m_req_valid), .req_ready_o(m_req_ready), .req_write_i(m_req_write),
    .req_id_i(m_req_id), .req_addr_i(m_req_addr), .req_wdata_i(m_req_wdata),
    .pass_i(pass),
    .fwd_valid_o(s_req_valid), .fwd_ready_i(s_req_ready), .fwd_write_o(s_req_write),
    .fwd_id_o(s_req_id), .fwd_addr_o(s_req_addr), .fwd_wdata_o(s_req_wdata),
    .dn_rsp_valid_i(s_rsp_valid), .dn_rsp_ready_o(s_rsp_ready),
    .dn_rsp_err_i(s_rsp_err), .dn_rsp_rdata_i(s_rsp_rdata),
    .up_rsp_valid_o(m_rsp_valid), .up_rsp_ready_i(m_rsp_ready),
    .up_rsp_err_o(m_rsp_err), .up_rsp_rdata_o(m_rsp_rdata),
    .reject_o(reject)
  );

  // R1
  out_win_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid && m_req_ready && !in_window |=> s_req_valid && (s_req_addr == $past(m_req_addr)));

  // R3
  blk_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid && m_req_ready && !pass |=> m_rsp_valid && m_rsp_err && (m_rsp_rdata == '0) && !s_req_valid);

endmodule

// File: tb/sim_acc_firewall.sv
module sim_acc_firewall;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_req_valid = 0, m_req_write = 0, m_req_priv = 0, m_rsp_ready = 1;
  logic [3:0]  m_req_id = 0;
  logic [31:0] m_req_addr = 0, m_req_wdata = 0;
  logic        s_req_ready = 1, s_rsp_valid = 0, s_rsp_err = 0;
  logic [31:0] s_rsp_rdata = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        m_req_ready, m_rsp_valid, m_rsp_err, s_req_valid, s_req_write, s_rsp_ready;
  logic [31:0] m_rsp_rdata, s_req_addr, s_req_wdata, cfg_rdata;
  logic [3:0]  s_req_id;

  acc_firewall u0 (.*);

  always #2.5ns clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0, stall_en = 0, bp_en = 0;
  int sl_lat = 1;
  string tag_dec = "R1";

  // reference model
  int ph = 0;
  logic        x_w, x_err, r_priv, r_lock, r_vv;
  logic [3:0]  x_id, r_vid;
  logic [31:0] x_addr, x_wd, x_rd, r_base, r_limit, r_vaddr;
  logic [15:0] r_allow;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; x_err = 0; x_rd = 0; x_w = 0; x_id = 0; x_addr = 0; x_wd = 0;
      r_base = 0; r_limit = 0; r_allow = 0; r_priv = 0; r_lock = 0;
      r_vv = 0; r_vid = 0; r_vaddr = 0;
    end else begin
      case (ph)
        0: if (m_req_valid) begin
             bit inwin, ok;
             inwin = (m_req_addr >= r_base) && (m_req_addr <= r_limit);
             ok = !inwin || (r_allow[m_req_id] && (!r_priv || m_req_priv));
             x_w = m_req_write; x_id = m_req_id; x_addr = m_req_addr; x_wd = m_req_wdata;
             if (ok) ph = 1;
             else begin
               ph = 3; x_err = 1; x_rd = 0;
               if (!r_vv) begin r_vv = 1; r_vid = m_req_id; r_vaddr = m_req_addr; end
             end
           end
        1: if (s_req_ready) ph = 2;
        2: if (s_rsp_valid) begin x_err = s_rsp_err; x_rd = s_rsp_rdata; ph = 3; end
        default: if (m_rsp_ready) ph = 0;
      endcase
      if (cfg_we && !r_lock) begin
        case (cfg_addr)
          3'd0: r_base = cfg_wdata;
          3'd1: r_limit = cfg_wdata;
          3'd2: r_allow = cfg_wdata[15:0];
          3'd3: begin r_priv = cfg_wdata[0]; r_lock = cfg_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_cfg(input logic [2:0] a);
    case (a)
      3'd0: return r_base;
      3'd1: return r_limit;
      3'd2: return {16'h0, r_allow};
      3'd3: return {30'h0, r_lock, r_priv};
      3'd4: return {r_vv, 27'h0, r_vid};
      3'd5: return r_vaddr;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && started) begin
    chk(m_req_ready == (ph == 0), "R5", "m_req_ready", 64'(m_req_ready), 64'(ph == 0));
    chk(s_req_valid == (ph == 1), tag_dec, "s_req_valid", 64'(s_req_valid), 64'(ph == 1));
    if (ph == 1)
      chk({s_req_write, s_req_id, s_req_addr} == {x_w, x_id, x_addr} && s_req_wdata == x_wd,
          "R5", "s_req payload", {s_req_write, s_req_id, s_req_addr}, {x_w, x_id, x_addr});
    chk(s_rsp_ready == (ph == 2), "R6", "s_rsp_ready", 64'(s_rsp_ready), 64'(ph == 2));
    chk(m_rsp_valid == (ph == 3), "R7", "m_rsp_valid", 64'(m_rsp_valid), 64'(ph == 3));
    if (ph == 3)
      chk({m_rsp_err, m_rsp_rdata} == {x_err, x_rd}, x_err ? "R3" : "R6", "m_rsp err/data",
          64'({m_rsp_err, m_rsp_rdata}), 64'({x_err, x_rd}));
    chk(cfg_rdata == exp_cfg(cfg_addr), cfg_addr >= 3'd4 ? "R10" : (r_lock ? "R9" : "R8"),
        "cfg_rdata", 64'(cfg_rdata), 64'(exp_cfg(cfg_addr)));
  end

  // emulated target
  logic sl_pend = 0;
  int   sl_wait = 0;
  logic [31:0] sl_addr = 0;
  always @(posedge clk) begin
    if (!rst_n) begin sl_pend <= 0; sl_wait <= 0; end
    else if (s_rsp_valid && s_rsp_ready) sl_pend <= 0;
    else if (s_req_valid && s_req_ready) begin sl_pend <= 1; sl_wait <= 0; sl_addr <= s_req_addr; end
    else if (sl_pend) sl_wait <= sl_wait + 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1ns;
    s_req_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    m_rsp_ready = bp_en ? (cyc % 2 == 1) : 1'b1;
    s_rsp_valid = sl_pend && (sl_wait >= sl_lat);
    s_rsp_err   = sl_addr[2];
    s_rsp_rdata = sl_addr ^ 32'h5A5A_0000;
    if (!cfg_we) cfg_addr = 3'(cyc % 6);
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 0;
  endtask

  task automatic issue(input bit w, input logic [3:0] id, input bit pv,
                       input logic [31:0] a, input logic [31:0] d, input string tag);
    bit acc;
    int guard;
    tag_dec = tag;
    m_req_valid = 1; m_req_write = w; m_req_id = id; m_req_priv = pv;
    m_req_addr = a; m_req_wdata = d;
    do begin acc = m_req_ready; step(); end while (!acc);
    m_req_valid = 0;
    guard = 0;
    while (ph != 0 && guard < 60) begin step(); guard++; end
    step();
  endtask

  initial begin
    logic [15:0] lfsr;
    // R11: reset state
    repeat (2) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      cfg_addr = 3'(k); #1ns;
      chk(cfg_rdata == 32'h0, "R11", "cfg reset value", 64'(cfg_rdata), 64'h0);
    end
    chk(m_req_ready && !s_req_valid && !m_rsp_valid && !s_rsp_ready, "R11", "outputs in reset",
        64'({m_req_ready, s_req_valid, m_rsp_valid, s_rsp_ready}), 64'h8);
    step();
    rst_n = 1; started = 1;
    step();
    // R3 + R10: window [0,0] with empty mask rejects address 0
    issue(0, 4'd5, 0, 32'h0, 32'h0, "R3");
    cfg_write(3'd0, 32'h1000);
    cfg_write(3'd1, 32'h1FFF);
    cfg_write(3'd2, 32'h0024);
    // R1: outside the window, boundaries just past it
    issue(0, 4'd7, 0, 32'h0800, 32'h0, "R1");
    issue(1, 4'd1, 0, 32'h2000, 32'hCAFE_0001, "R1");
    issue(0, 4'd3, 0, 32'h0FFF, 32'h0, "R1");
    // R2: allowed identifiers inside, on both bounds
    issue(0, 4'd2, 0, 32'h1000, 32'h0, "R2");
    issue(1, 4'd5, 0, 32'h1FFF, 32'h1234_5678, "R2");
    issue(0, 4'd5, 0, 32'h1234, 32'h0, "R2");
    // R3: disallowed identifiers inside; record keeps the first violation (R10)
    issue(0, 4'd3, 1, 32'h1004, 32'h0, "R3");
    issue(1, 4'd0, 1, 32'h1FFC, 32'hDEAD_BEEF, "R3");
    // R5/R6 under back-pressure on every channel
    stall_en = 1; bp_en = 1; sl_lat = 3;
    issue(0, 4'd2, 0, 32'h1010, 32'h0, "R5");
    issue(1, 4'd9, 0, 32'h3004, 32'h55AA_55AA, "R6");
    issue(0, 4'd4, 0, 32'h1800, 32'h0, "R7");
    // R4: privileged-only switch
    cfg_write(3'd3, 32'h1);
    issue(0, 4'd2, 0, 32'h1100, 32'h0, "R4");
    issue(0, 4'd2, 1, 32'h1100, 32'h0, "R4");
    issue(0, 4'd9, 0, 32'h4000, 32'h0, "R4");
    // R9: lock, then attempted rewrites have no effect
    cfg_write(3'd3, 32'h3);
    cfg_write(3'd0, 32'h0);
    cfg_write(3'd2, 32'hFFFF);
    cfg_write(3'd3, 32'h0);
    issue(0, 4'd3, 1, 32'h1000, 32'h0, "R9");
    issue(0, 4'd2, 0, 32'h1000, 32'h0, "R9");
    issue(0, 4'd2, 1, 32'h1FF0, 32'h0, "R9");
    // R8: unused offsets read zero while the model compares every cycle
    for (int k = 0; k < 8; k++) cfg_write(3'd6, 32'hFFFF_FFFF);
    // mixed sweep
    lfsr = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sl_lat = n % 3;
      issue(lfsr[0], lfsr[4:1], lfsr[5], 32'h0F00 + 32'({lfsr[15:6], 2'b00}), 32'(lfsr), "R4");
    end
    repeat (4) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule